// File: doc/BRIEF.md
# Internal Test Trigger Sequencer

This block lets a readout board make its own trigger sequence for test and calibration runs, with no trigger from outside. A start command reaches the board with a target address and a broadcast flag. The block accepts the command when it is idle and when the command is either broadcast or addressed to this board. It then produces a level-0 pulse, a level-1 pulse after a first programmed wait, and a level-2 pulse after a second programmed wait.

Both waits come from timeout values that are held elsewhere on the board. The level-1 wait is the level-1 timeout less one cycle. The level-2 wait is the level-2 timeout less two cycles. Both are clamped at zero and are captured when the command is accepted. The generated level-0 and level-1 pulses are ORed into the external trigger lines that feed the normal trigger handler. The level-1 and level-2 pulses also drive the lines that go to the digitizers. A busy flag covers the whole sequence, and start commands that arrive while it is high are dropped.

Top module: `trig_test_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, the outputs dig_l1_o, dig_l2_o and busy_o are low, and hdl_l0_o and hdl_l1_o follow the external trigger inputs only.
- R2: A start is accepted only when busy_o is low and either cmd_bcast_i is 1 or cmd_addr_i equals board_addr_i. An accepted start sampled at a clock edge produces a level-0 pulse that is exactly one cycle wide, in the cycle that follows that edge.
- R3: A start with cmd_bcast_i at 0 and cmd_addr_i different from board_addr_i is ignored: no pulse appears and busy_o stays low.
- R4: The level-1 pulse is one cycle wide. It appears max(l1_timeout_i − 1, 0) cycles after the level-0 cycle, so a wait of zero puts it in the same cycle as level-0. It shows on dig_l1_o and on hdl_l1_o.
- R5: The level-2 pulse is one cycle wide. It appears max(l2_timeout_i − 2, 0) cycles after the level-1 cycle, on dig_l2_o only.
- R6: Both timeout values are sampled at the edge that accepts the start. Later changes have no effect on the sequence that is running.
- R7: busy_o is high from the level-0 cycle through the level-2 cycle, inclusive, and low at every other time.
- R8: A start sampled while busy_o is high is ignored, including during the level-2 cycle. A start held high is accepted at the first edge after busy_o falls.
- R9: hdl_l0_o is the OR of ext_l0_i and the generated level-0 pulse, and hdl_l1_o is the OR of ext_l1_i and the generated level-1 pulse. External triggers never start a sequence and never change its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start_i | input | 1 | Start-command strobe |
| cmd_bcast_i | input | 1 | Command is broadcast to every board |
| cmd_addr_i | input | ADDR_W | Target board address of the command |
| board_addr_i | input | ADDR_W | This board's address |
| l1_timeout_i | input | TO_W | Level-1 timeout value |
| l2_timeout_i | input | TO_W | Level-2 timeout value |
| ext_l0_i | input | 1 | External level-0 trigger |
| ext_l1_i | input | 1 | External level-1 trigger |
| hdl_l0_o | output | 1 | Level-0 to the trigger handler (external OR generated) |
| hdl_l1_o | output | 1 | Level-1 to the trigger handler (external OR generated) |
| dig_l1_o | output | 1 | Generated level-1 to the digitizers |
| dig_l2_o | output | 1 | Generated level-2 to the digitizers |
| busy_o | output | 1 | Sequence in progress |

## Verification
The bench builds the block with TO_W = 8 and ADDR_W = 3. With these widths the largest timeout, 255, gives a sequence of about 500 cycles, which is short enough to run in full. The small values 0, 1 and 2 are also in range; they clamp to zero and make pulses land in the same cycle. The three-bit address leaves room for mismatched addresses to test that a command is ignored. Random external triggers run alongside sequences that start at short spacing, so the OR merge and the drop of busy-time starts are checked together.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
    localparam int unsigned L1_OFFSET = 1;
    localparam int unsigned L2_OFFSET = 2;

    typedef enum logic {
        PH_WAIT_L1 = 1'b0,
        PH_WAIT_L2 = 1'b1
    } seq_phase_e;
endpackage

// File: rtl/trig_wait_calc.sv
module trig_wait_calc #(
    parameter int unsigned TO_W   = 16,
    parameter int unsigned OFFSET = 1
) (
    input  logic [TO_W-1:0] timeout_i,
    output logic [TO_W-1:0] wait_o
);
    localparam logic [TO_W-1:0] OFS = TO_W'(OFFSET);

    generate
        if (OFFSET == 0) begin : g_pass
            assign wait_o = timeout_i;
        end else begin : g_clamp
            assign wait_o = (timeout_i > OFS) ? (timeout_i - OFS) : '0;
        end
    endgenerate
endmodule

// File: rtl/trig_seq_core.sv
module trig_seq_core
    import trig_seq_pkg::*;
#(
    parameter int unsigned TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go_i,
    input  logic [TO_W-1:0] wait1_i,
    input  logic [TO_W-1:0] wait2_i,
    output logic            l0_o,
    output logic            l1_o,
    output logic            l2_o,
    output logic            busy_o
);
    localparam logic [TO_W-1:0] ONE = TO_W'(1);

    typedef struct packed {
        logic            busy;
        logic            l0;
        logic            l1;
        logic            l2;
        seq_phase_e      phase;
        logic [TO_W-1:0] cnt;
        logic [TO_W-1:0] wait2;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.l0 = 1'b0;
        st_d.l1 = 1'b0;
        st_d.l2 = 1'b0;
        if (!st_q.busy) begin
            if (go_i) begin
                st_d.busy  = 1'b1;
                st_d.l0    = 1'b1;
                st_d.wait2 = wait2_i;
                if (wait1_i == '0) begin
                    st_d.l1    = 1'b1;
                    st_d.phase = PH_WAIT_L2;
                    st_d.cnt   = wait2_i;
                    st_d.l2    = (wait2_i == '0);
                end else begin
                    st_d.phase = PH_WAIT_L1;
                    st_d.cnt   = wait1_i;
                end
            end
        end else if (st_q.l2) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
        end else if (st_q.cnt == ONE) begin
            if (st_q.phase == PH_WAIT_L1) begin
                st_d.l1    = 1'b1;
                st_d.phase = PH_WAIT_L2;
                st_d.cnt   = st_q.wait2;
                st_d.l2    = (st_q.wait2 == '0);
            end else begin
                st_d.l2  = 1'b1;
                st_d.cnt = '0;
            end
        end else begin
            st_d.cnt = st_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign l0_o   = st_q.l0;
    assign l1_o   = st_q.l1;
    assign l2_o   = st_q.l2;
    assign busy_o = st_q.busy;

    // R2
    l0_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l0_o |=> !l0_o);

    // R8
    l0_idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l0_o |-> !$past(busy_o));

    // R7
    l2_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l2_o |=> !busy_o);

    // R7
    busy_starts_l0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> l0_o);

    // R4
    l1_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l1_o |=> !l1_o);

    // R5
    l2_inside_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l2_o |-> busy_o);
endmodule

// File: rtl/trig_test_seq.sv
module trig_test_seq
    import trig_seq_pkg::*;
#(
    parameter int unsigned TO_W   = 16,
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start_i,
    input  logic              cmd_bcast_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic [ADDR_W-1:0] board_addr_i,
    input  logic [TO_W-1:0]   l1_timeout_i,
    input  logic [TO_W-1:0]   l2_timeout_i,
    input  logic              ext_l0_i,
    input  logic              ext_l1_i,
    output logic              hdl_l0_o,
    output logic              hdl_l1_o,
    output logic              dig_l1_o,
    output logic              dig_l2_o,
    output logic              busy_o
);
    logic            go;
    logic [TO_W-1:0] wait1, wait2;
    logic            gen_l0, gen_l1, gen_l2;

    assign go = cmd_start_i && (cmd_bcast_i || (cmd_addr_i == board_addr_i));

    trig_wait_calc #(.TO_W(TO_W), .OFFSET(L1_OFFSET)) u_wait1 (
        .timeout_i (l1_timeout_i),
        .wait_o    (wait1)
    );

    trig_wait_calc #(.TO_W(TO_W), .OFFSET(L2_OFFSET)) u_wait2 (
        .timeout_i (l2_timeout_i),
        .wait_o    (wait2)
    );

    trig_seq_core #(.TO_W(TO_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (go),
        .wait1_i (wait1),
        .wait2_i (wait2),
        .l0_o    (gen_l0),
        .l1_o    (gen_l1),
        .l2_o    (gen_l2),
        .busy_o  (busy_o)
    );

    assign hdl_l0_o = ext_l0_i | gen_l0;
    assign hdl_l1_o = ext_l1_i | gen_l1;
    assign dig_l1_o = gen_l1;
    assign dig_l2_o = gen_l2;

    // R9
    l2_no_handler_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_l2_o && !dig_l1_o && !ext_l1_i) |-> !hdl_l1_o);
endmodule

// File: tb/trig_test_seq_tb.sv
module trig_test_seq_tb_top;
    localparam int unsigned TO_W   = 8;
    localparam int unsigned ADDR_W = 3;
    localparam logic [ADDR_W-1:0] MY_ADDR = 3'd5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_start_i = 1'b0;
    logic              cmd_bcast_i = 1'b0;
    logic [ADDR_W-1:0] cmd_addr_i = '0;
    logic [TO_W-1:0]   l1_timeout_i = '0;
    logic [TO_W-1:0]   l2_timeout_i = '0;
    logic              ext_l0_i = 1'b0;
    logic              ext_l1_i = 1'b0;
    logic              ext_en = 1'b0;
    logic              hdl_l0_o, hdl_l1_o, dig_l1_o, dig_l2_o, busy_o;

    int    tests = 0;
    int    fails = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    trig_test_seq #(.TO_W(TO_W), .ADDR_W(ADDR_W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_start_i  (cmd_start_i),
        .cmd_bcast_i  (cmd_bcast_i),
        .cmd_addr_i   (cmd_addr_i),
        .board_addr_i (MY_ADDR),
        .l1_timeout_i (l1_timeout_i),
        .l2_timeout_i (l2_timeout_i),
        .ext_l0_i     (ext_l0_i),
        .ext_l1_i     (ext_l1_i),
        .hdl_l0_o     (hdl_l0_o),
        .hdl_l1_o     (hdl_l1_o),
        .dig_l1_o     (dig_l1_o),
        .dig_l2_o     (dig_l2_o),
        .busy_o       (busy_o)
    );

    // behavioural reference: absolute cycle numbers of each pulse
    longint cyc = 0;
    longint t0 = -100, t1 = -100, t2 = -100;

    function automatic bit m_busy(longint c);
        return (c >= t0) && (c <= t2);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            t0 = -100; t1 = -100; t2 = -100;
        end else if (cmd_start_i && (cmd_bcast_i || cmd_addr_i == MY_ADDR) && !m_busy(cyc)) begin
            longint d1, d2;
            d1 = (l1_timeout_i > 1) ? longint'(l1_timeout_i) - 1 : 0;
            d2 = (l2_timeout_i > 2) ? longint'(l2_timeout_i) - 2 : 0;
            t0 = cyc + 1;
            t1 = t0 + d1;
            t2 = t1 + d2;
        end
        cyc = cyc + 1;
    end

    always @(posedge clk) begin
        #2;
        if (ext_en) begin
            ext_l0_i = ($urandom_range(0, 7) == 0);
            ext_l1_i = ($urandom_range(0, 7) == 0);
        end else begin
            ext_l0_i = 1'b0;
            ext_l1_i = 1'b0;
        end
    end

    task automatic cmp(string req, string what, logic act, logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s cycle %0d actual %b expected %b", req, what, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            cmp("R1", "busy in reset", busy_o, 1'b0);
            cmp("R1", "dig_l1 in reset", dig_l1_o, 1'b0);
            cmp("R1", "dig_l2 in reset", dig_l2_o, 1'b0);
            cmp("R1", "hdl_l0 in reset", hdl_l0_o, ext_l0_i);
        end else begin
            cmp({cur_req, "/R2"}, "hdl_l0", hdl_l0_o, ext_l0_i | (cyc == t0));
            cmp({cur_req, "/R4"}, "dig_l1", dig_l1_o, (cyc == t1));
            cmp({cur_req, "/R9"}, "hdl_l1", hdl_l1_o, ext_l1_i | (cyc == t1));
            cmp({cur_req, "/R5"}, "dig_l2", dig_l2_o, (cyc == t2));
            cmp({cur_req, "/R7"}, "busy", busy_o, m_busy(cyc));
        end
    end

    task automatic step(int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic issue(logic [ADDR_W-1:0] a, logic b, int l1, int l2);
        cmd_addr_i   = a;
        cmd_bcast_i  = b;
        l1_timeout_i = TO_W'(l1);
        l2_timeout_i = TO_W'(l2);
        cmd_start_i  = 1'b1;
        step();
        cmd_start_i  = 1'b0;
    endtask

    task automatic drain();
        step(2);
        while (busy_o) step();
        step(2);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog expired, busy actual %b expected 0", busy_o);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        step(4);
        rst_n = 1'b1;
        cur_req = "R1";
        step(3);

        ext_en = 1'b1;
        cur_req = "R2"; issue(MY_ADDR, 1'b0, 5, 7); drain();
        cur_req = "R3"; issue(3'd2, 1'b0, 4, 4); step(12);
        cur_req = "R3"; issue(3'd6, 1'b0, 0, 0); step(6);
        cur_req = "R2"; issue(3'd1, 1'b1, 3, 5); drain();
        cur_req = "R4"; issue(MY_ADDR, 1'b0, 0, 0); drain();
        cur_req = "R4"; issue(MY_ADDR, 1'b0, 1, 1); drain();
        cur_req = "R5"; issue(MY_ADDR, 1'b0, 2, 2); drain();
        cur_req = "R5"; issue(MY_ADDR, 1'b0, 2, 3); drain();
        cur_req = "R4"; issue(MY_ADDR, 1'b0, 9, 0); drain();

        cur_req = "R6";
        issue(MY_ADDR, 1'b0, 6, 8);
        l1_timeout_i = 8'd1; l2_timeout_i = 8'd200;
        step(3);
        l1_timeout_i = 8'd40; l2_timeout_i = 8'd0;
        drain();

        cur_req = "R8";
        issue(MY_ADDR, 1'b0, 6, 6);
        step(3);
        issue(MY_ADDR, 1'b1, 2, 2);
        step(4);
        issue(MY_ADDR, 1'b0, 0, 0);
        drain();

        cur_req = "R8";
        cmd_addr_i = MY_ADDR; cmd_bcast_i = 1'b0;
        l1_timeout_i = 8'd3; l2_timeout_i = 8'd4;
        cmd_start_i = 1'b1;
        step(40);
        l1_timeout_i = 8'd0; l2_timeout_i = 8'd0;
        step(10);
        cmd_start_i = 1'b0;
        drain();

        cur_req = "R9";
        issue(MY_ADDR, 1'b0, 12, 15); drain();
        step(30);

        cur_req = "R5"; issue(3'd0, 1'b1, 255, 255); drain();

        ext_en = 1'b0;
        cur_req = "R1";
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(3);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule